// File: doc/BRIEF.md
# Trap Entry State Capture

This block records the machine-mode trap state at the moment a trap is taken. When the core raises a trap request, it presents the cause code, a flag that marks an asynchronous interrupt, the PC of the trapping instruction, the PC of the following instruction, the instruction word and the data address involved. On the next clock edge the block loads three registers. The saved return PC holds where execution resumes, the trap value holds the extra detail for the handler, and the cause register holds the interrupt flag and the code.

The trap value is filled according to the cause. A zero trap value always tells the handler that the detail was not supplied and must be recovered by software. Typical cases are a misaligned instruction fetch, which cannot be restarted, and every interrupt. Illegal-instruction traps carry the offending instruction word, unless a build option selects zero for them as well.

Software reads the three registers through a selected read port and writes them through a write port. A write lands on the next cycle. When a trap is captured in the same cycle as a write, the trap capture takes priority.

Top module: `trap_capture`

## Requirements
- R1: After synchronous active-low reset, the saved return PC, the trap value and the cause register all read zero.
- R2: On an interrupt trap (`trap_irq`=1), the saved return PC becomes `trap_npc` and the trap value becomes zero. The cause register becomes `trap_code` zero-extended, with bit XLEN-1 set to 1. All three are visible one cycle after `trap_valid`.
- R3: On a synchronous exception (`trap_irq`=0), the saved return PC becomes `trap_pc`, and the cause register becomes `trap_code` zero-extended with bit XLEN-1 cleared.
- R4: For breakpoint (code 3) and environment calls (codes 8, 9, 11), the saved return PC is the trapping instruction's own `trap_pc`, not `trap_npc`, and the trap value is zero.
- R5: For illegal instruction (code 2), the trap value is `trap_insn` when parameter ILL_INSN_ZERO is 0, and zero when it is 1.
- R6: For misaligned instruction fetch (code 0), the trap value is zero whatever `trap_addr` holds.
- R7: For load misaligned (4), load access fault (5), store misaligned (6) and store access fault (7), the trap value is `trap_addr`.
- R8: Every other exception code, for example fetch access fault (1), yields a zero trap value.
- R9: With `sw_we`=1 and no trap, `sw_wdata` is written one cycle later to the register chosen by `sw_sel`: 0 for the return PC, 1 for the trap value, 2 for the cause. Select value 3 writes nothing.
- R10: When `trap_valid` and `sw_we` are both high in the same cycle, all three registers take the trap values and the software write is dropped.
- R11: Bit 0 of the saved return PC is always zero, both on trap capture and on a software write.
- R12: `sw_rdata` combinationally returns the register chosen by `sw_sel` (same encoding as R9). Select value 3 returns zero.
- R13: With neither a trap nor a software write, all three registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | Trap is taken this cycle |
| trap_irq | input | 1 | Trap is an asynchronous interrupt |
| trap_code | input | CODE_W | Exception or interrupt code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_npc | input | XLEN | PC of the next instruction |
| trap_insn | input | XLEN | Instruction word of the trapping instruction |
| trap_addr | input | XLEN | Data address of a faulting access |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Register select: 0 return PC, 1 trap value, 2 cause, 3 none |
| sw_wdata | input | XLEN | Software write data |
| sw_rdata | output | XLEN | Software read data for the selected register |
| epc_q | output | XLEN | Saved return PC |
| tval_q | output | XLEN | Trap value |
| cause_q | output | XLEN | Cause register |

## Verification
The bench presents traps whose unused inputs carry distinctive non-zero patterns. A design that routed the wrong source into the trap value shows that pattern in place of zero. Examples are the data address on a misaligned fetch or the instruction word on a breakpoint. Interrupts and environment calls use different PCs, so a design that confused the two resume points, or that advanced past an ecall, saves a visibly wrong PC. A software write collides with a trap, and a second instance built for zero on illegal instructions runs alongside. A design with the wrong priority, or one that ignores the build option, is therefore caught directly. Odd PCs and odd write data expose a return PC that keeps bit 0.

// File: rtl/trap_cap_pkg.sv
// Package: shared codes and types for the trap entry capture block.
// Assumes standard machine-mode exception code numbering.
package trap_cap_pkg;

    // Software register select encoding
    typedef enum logic [1:0] {
        SEL_EPC   = 2'd0,
        SEL_TVAL  = 2'd1,
        SEL_CAUSE = 2'd2,
        SEL_NONE  = 2'd3
    } csr_sel_e;

    // Where the trap value comes from
    typedef enum logic [1:0] {
        TV_ZERO = 2'd0,
        TV_INSN = 2'd1,
        TV_ADDR = 2'd2
    } tval_src_e;

    // Exception codes whose trap value handling differs
    localparam int EXC_FETCH_MISALIGN = 0;
    localparam int EXC_FETCH_FAULT    = 1;
    localparam int EXC_ILLEGAL        = 2;
    localparam int EXC_BREAK          = 3;
    localparam int EXC_LOAD_MISALIGN  = 4;
    localparam int EXC_LOAD_FAULT     = 5;
    localparam int EXC_STORE_MISALIGN = 6;
    localparam int EXC_STORE_FAULT    = 7;

    localparam int NUM_TRAP_REGS = 3;

endpackage

// File: rtl/trap_tval_sel.sv
// Module: trap_tval_sel
// Picks the trap value for a trap from its cause. A zero value marks
// "detail not supplied". Assumes the code is meaningful only when irq=0.
module trap_tval_sel
    import trap_cap_pkg::*;
#(
    parameter int XLEN          = 32,
    parameter int CODE_W        = 6,
    parameter bit ILL_INSN_ZERO = 1'b0
) (
    input  logic              irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   insn,
    input  logic [XLEN-1:0]   addr,
    output tval_src_e         src,
    output logic [XLEN-1:0]   tval
);

    localparam logic [CODE_W-1:0] C_ILL = CODE_W'(EXC_ILLEGAL);
    localparam logic [CODE_W-1:0] C_LMA = CODE_W'(EXC_LOAD_MISALIGN);
    localparam logic [CODE_W-1:0] C_LAF = CODE_W'(EXC_LOAD_FAULT);
    localparam logic [CODE_W-1:0] C_SMA = CODE_W'(EXC_STORE_MISALIGN);
    localparam logic [CODE_W-1:0] C_SAF = CODE_W'(EXC_STORE_FAULT);

    logic [XLEN-1:0] ill_word;

    // Build option: supply the instruction word or the zero hint on illegal
    generate
        if (ILL_INSN_ZERO) begin : g_ill_zero
            assign ill_word = '0;
        end else begin : g_ill_word
            assign ill_word = insn;
        end
    endgenerate

    // Classify the cause into a trap value source
    always_comb begin
        if (irq) begin
            src = TV_ZERO;
        end else begin
            case (code)
                C_ILL:                      src = TV_INSN;
                C_LMA, C_LAF, C_SMA, C_SAF: src = TV_ADDR;
                default:                    src = TV_ZERO;
            endcase
        end
    end

    // Route the chosen source to the value
    always_comb begin
        case (src)
            TV_INSN: tval = ill_word;
            TV_ADDR: tval = addr;
            default: tval = '0;
        endcase
    end

endmodule

// File: rtl/trap_cause_pc.sv
// Module: trap_cause_pc
// Forms the resume PC and the cause word for a trap. Interrupts resume
// at the next PC, exceptions at the trapping PC. Assumes CODE_W < XLEN-1.
module trap_cause_pc #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 6
) (
    input  logic              irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   npc,
    output logic [XLEN-1:0]   epc,
    output logic [XLEN-1:0]   cause
);

    localparam int PAD_W = XLEN - 1 - CODE_W;

    // Choose the resume point and drop the low bit
    always_comb begin
        epc      = irq ? npc : pc;
        epc[0]   = 1'b0;
    end

    // Pack the interrupt flag above the zero-extended code
    always_comb begin
        cause = {irq, {PAD_W{1'b0}}, code};
    end

endmodule

// File: rtl/trap_csr_cell.sv
// Module: trap_csr_cell
// One trap register: reset to zero, trap capture over software write,
// software write masked by WMASK. Assumes cap and wr are single-cycle strobes.
module trap_csr_cell #(
    parameter int            W     = 32,
    parameter logic [W-1:0]  WMASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] cap_val,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Register update with trap capture taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap) begin
            q <= cap_val;
        end else if (wr) begin
            q <= wdata & WMASK;
        end
    end

    // Capture beats a same-cycle software write
    assert_capture_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (q == $past(cap_val)));

    // Software write lands one cycle later when no trap is present
    assert_sw_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !cap) |=> (q == ($past(wdata) & WMASK)));

endmodule

// File: rtl/trap_capture.sv
// Module: trap_capture (top)
// Captures resume PC, trap value and cause on trap entry, and gives software
// read/write access to the three registers. Assumes trap_valid is a
// one-cycle strobe from the core's commit logic.
module trap_capture
    import trap_cap_pkg::*;
#(
    parameter int XLEN          = 32,
    parameter int CODE_W        = 6,
    parameter bit ILL_INSN_ZERO = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_npc,
    input  logic [XLEN-1:0]   trap_insn,
    input  logic [XLEN-1:0]   trap_addr,
    input  logic              sw_we,
    input  logic [1:0]        sw_sel,
    input  logic [XLEN-1:0]   sw_wdata,
    output logic [XLEN-1:0]   sw_rdata,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-1:0]   tval_q,
    output logic [XLEN-1:0]   cause_q
);

    localparam logic [XLEN-1:0] EPC_MASK = ~XLEN'(1);
    localparam logic [XLEN-1:0] ALL_MASK = {XLEN{1'b1}};

    tval_src_e       tv_src;
    logic [XLEN-1:0] tv_val;
    logic [XLEN-1:0] pc_val;
    logic [XLEN-1:0] cause_val;
    logic [XLEN-1:0] cap_val [NUM_TRAP_REGS];
    logic [XLEN-1:0] reg_q   [NUM_TRAP_REGS];
    csr_sel_e        sel;

    assign sel = csr_sel_e'(sw_sel);

    trap_tval_sel #(
        .XLEN          (XLEN),
        .CODE_W        (CODE_W),
        .ILL_INSN_ZERO (ILL_INSN_ZERO)
    ) i_tval_sel (
        .irq  (trap_irq),
        .code (trap_code),
        .insn (trap_insn),
        .addr (trap_addr),
        .src  (tv_src),
        .tval (tv_val)
    );

    trap_cause_pc #(
        .XLEN   (XLEN),
        .CODE_W (CODE_W)
    ) i_cause_pc (
        .irq   (trap_irq),
        .code  (trap_code),
        .pc    (trap_pc),
        .npc   (trap_npc),
        .epc   (pc_val),
        .cause (cause_val)
    );

    assign cap_val[SEL_EPC]   = pc_val;
    assign cap_val[SEL_TVAL]  = tv_val;
    assign cap_val[SEL_CAUSE] = cause_val;

    // One register cell per trap register; only the PC drops bit 0 on write
    generate
        for (genvar k = 0; k < NUM_TRAP_REGS; k++) begin : g_cell
            localparam logic [XLEN-1:0] MASK = (k == int'(SEL_EPC)) ? EPC_MASK : ALL_MASK;
            logic wr_k;
            assign wr_k = sw_we && (sw_sel == 2'(k));
            trap_csr_cell #(
                .W     (XLEN),
                .WMASK (MASK)
            ) i_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .cap     (trap_valid),
                .cap_val (cap_val[k]),
                .wr      (wr_k),
                .wdata   (sw_wdata),
                .q       (reg_q[k])
            );
        end
    endgenerate

    assign epc_q   = reg_q[SEL_EPC];
    assign tval_q  = reg_q[SEL_TVAL];
    assign cause_q = reg_q[SEL_CAUSE];

    // Software read multiplexer
    always_comb begin
        case (sel)
            SEL_EPC:   sw_rdata = epc_q;
            SEL_TVAL:  sw_rdata = tval_q;
            SEL_CAUSE: sw_rdata = cause_q;
            default:   sw_rdata = '0;
        endcase
    end

    // Interrupt: resume at next PC, zero value, flag set
    assert_irq_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_irq) |=>
            (epc_q == ($past(trap_npc) & EPC_MASK)) && (tval_q == '0) && cause_q[XLEN-1]);

    // Exception: resume at trapping PC, flag clear
    assert_exc_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_irq) |=>
            (epc_q == ($past(trap_pc) & EPC_MASK)) && !cause_q[XLEN-1]);

    // Misaligned fetch always yields the zero hint
    assert_fetch_misalign_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_irq && (trap_code == CODE_W'(EXC_FETCH_MISALIGN))) |=> (tval_q == '0));

    // Data-side faults report the data address
    assert_data_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_irq && (trap_code >= CODE_W'(EXC_LOAD_MISALIGN))
            && (trap_code <= CODE_W'(EXC_STORE_FAULT))) |=> (tval_q == $past(trap_addr)));

    // Saved PC never has bit 0 set
    assert_epc_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !epc_q[0]);

    // Idle cycles leave every register alone
    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_valid && !sw_we) |=> ($stable(epc_q) && $stable(tval_q) && $stable(cause_q)));

endmodule

// File: tb/test_trap_capture.sv
// Scoreboard bench: a driver task applies one operation per cycle and queues
// the expected register state; a monitor pops and compares on each falling edge.
module test_trap_capture;

    localparam int XLEN   = 32;
    localparam int CODE_W = 6;

    typedef struct {
        logic [31:0] epc;
        logic [31:0] tval;
        logic [31:0] tvalz;
        logic [31:0] cause;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trap_valid = 1'b0;
    logic              trap_irq = 1'b0;
    logic [CODE_W-1:0] trap_code = '0;
    logic [XLEN-1:0]   trap_pc = '0, trap_npc = '0, trap_insn = '0, trap_addr = '0;
    logic              sw_we = 1'b0;
    logic [1:0]        sw_sel = 2'd0;
    logic [XLEN-1:0]   sw_wdata = '0;
    logic [XLEN-1:0]   sw_rdata, epc_q, tval_q, cause_q;
    logic [XLEN-1:0]   sw_rdata_z, epc_z, tval_z, cause_z;

    int checks = 0;
    int errors = 0;
    exp_t sbq[$];
    exp_t mon_e;
    logic [31:0] m_epc = '0, m_tval = '0, m_tvalz = '0, m_cause = '0;

    always #5 clk = ~clk;

    trap_capture #(.XLEN(XLEN), .CODE_W(CODE_W), .ILL_INSN_ZERO(1'b0)) i_trap_capture (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_irq(trap_irq),
        .trap_code(trap_code), .trap_pc(trap_pc), .trap_npc(trap_npc),
        .trap_insn(trap_insn), .trap_addr(trap_addr), .sw_we(sw_we), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .epc_q(epc_q), .tval_q(tval_q),
        .cause_q(cause_q));

    trap_capture #(.XLEN(XLEN), .CODE_W(CODE_W), .ILL_INSN_ZERO(1'b1)) i_trap_capture_z (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_irq(trap_irq),
        .trap_code(trap_code), .trap_pc(trap_pc), .trap_npc(trap_npc),
        .trap_insn(trap_insn), .trap_addr(trap_addr), .sw_we(sw_we), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata_z), .epc_q(epc_z), .tval_q(tval_z),
        .cause_q(cause_z));

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Trap value expected from the requirements (R5 R6 R7 R8, R2 zero)
    function automatic logic [31:0] exp_tval(input bit z, input logic irq, input int code,
                                             input logic [31:0] insn, input logic [31:0] addr);
        if (irq) return 32'h0;
        case (code)
            2:          return z ? 32'h0 : insn;
            4, 5, 6, 7: return addr;
            default:    return 32'h0;
        endcase
    endfunction

    // Driver: one operation per cycle, expected state pushed after the edge
    task automatic step(input string tag, input logic valid, input logic irq, input int code,
                        input logic [31:0] pc, input logic [31:0] npc, input logic [31:0] insn,
                        input logic [31:0] addr, input logic we, input logic [1:0] sel,
                        input logic [31:0] wd);
        exp_t e;
        @(negedge clk);
        trap_valid = valid; trap_irq = irq; trap_code = CODE_W'(code);
        trap_pc = pc; trap_npc = npc; trap_insn = insn; trap_addr = addr;
        sw_we = we; sw_sel = sel; sw_wdata = wd;
        if (valid) begin
            m_epc   = (irq ? npc : pc) & ~32'h1;
            m_tval  = exp_tval(1'b0, irq, code, insn, addr);
            m_tvalz = exp_tval(1'b1, irq, code, insn, addr);
            m_cause = {irq, 25'h0, 6'(code)};
        end else if (we) begin
            case (sel)
                2'd0: m_epc = wd & ~32'h1;
                2'd1: begin m_tval = wd; m_tvalz = wd; end
                2'd2: m_cause = wd;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        e.epc = m_epc; e.tval = m_tval; e.tvalz = m_tvalz; e.cause = m_cause; e.tag = tag;
        sbq.push_back(e);
        trap_valid = 1'b0; sw_we = 1'b0;
    endtask

    // Combinational read port check with no write or trap pending
    task automatic read_chk(input string tag, input logic [1:0] sel, input logic [31:0] exp);
        @(negedge clk);
        trap_valid = 1'b0; sw_we = 1'b0; sw_sel = sel;
        #1;
        chk({tag, " rdata"}, sw_rdata, exp);
    endtask

    // Monitor: compare registered outputs against the queued expectation
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            mon_e = sbq.pop_front();
            chk({mon_e.tag, " epc"},   epc_q,   mon_e.epc);
            chk({mon_e.tag, " tval"},  tval_q,  mon_e.tval);
            chk({mon_e.tag, " cause"}, cause_q, mon_e.cause);
            chk({mon_e.tag, " tval(zero option)"}, tval_z, mon_e.tvalz);
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 epc", epc_q, 32'h0);
        chk("R1 tval", tval_q, 32'h0);
        chk("R1 cause", cause_q, 32'h0);

        // R2: interrupts resume at next PC, zero value, top bit set
        step("R2 irq7", 1, 1, 7, 32'h1000, 32'h1004, 32'hAAAA5555, 32'h12345678, 0, 0, 0);
        step("R2 irq11", 1, 1, 11, 32'h2000, 32'h2002, 32'h11111111, 32'h0BAD0BAD, 0, 0, 0);
        // R4: ecall / breakpoint keep their own PC
        step("R4 ecall-m", 1, 0, 11, 32'h3000, 32'h3004, 32'h00000073, 32'hCAFE0000, 0, 0, 0);
        step("R4 ecall-u", 1, 0, 8, 32'h3100, 32'h3104, 32'h00000073, 32'hCAFE0001, 0, 0, 0);
        step("R4 break", 1, 0, 3, 32'h3200, 32'h3204, 32'h00100073, 32'hCAFE0002, 0, 0, 0);
        // R5: illegal instruction word (zero in the option instance)
        step("R5 illegal", 1, 0, 2, 32'h4000, 32'h4004, 32'hDEADBEEF, 32'h55550000, 0, 0, 0);
        // R6: misaligned fetch gives zero
        step("R6 fetch-mis", 1, 0, 0, 32'h4100, 32'h4104, 32'h12121212, 32'h00001235, 0, 0, 0);
        // R7: data faults give the address
        step("R7 ld-mis", 1, 0, 4, 32'h4200, 32'h4204, 32'h34343434, 32'h80001001, 0, 0, 0);
        step("R7 ld-fault", 1, 0, 5, 32'h4300, 32'h4304, 32'h34343434, 32'h90000000, 0, 0, 0);
        step("R7 st-mis", 1, 0, 6, 32'h4400, 32'h4404, 32'h34343434, 32'hA0000003, 0, 0, 0);
        step("R7 st-fault", 1, 0, 7, 32'h4500, 32'h4504, 32'h34343434, 32'hB0000008, 0, 0, 0);
        // R8: other codes give zero
        step("R8 fetch-fault", 1, 0, 1, 32'h4600, 32'h4604, 32'h56565656, 32'hC0000000, 0, 0, 0);
        step("R8 code13", 1, 0, 13, 32'h4700, 32'h4704, 32'h56565656, 32'hC0000004, 0, 0, 0);
        // R3: exception cause flag clear, PC from trap_pc; R11 odd PC
        step("R3 R11 odd-pc", 1, 0, 5, 32'h7001, 32'h7005, 32'h0, 32'hD0000001, 0, 0, 0);
        // R13: idle cycle holds
        step("R13 hold", 0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 0);
        // R9: software writes, R11 odd write data
        step("R9 R11 wr-epc", 0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h00005555);
        step("R9 wr-tval", 0, 0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h13579BDF);
        step("R9 wr-cause", 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 32'h8000000B);
        step("R9 wr-sel3", 0, 0, 0, 0, 0, 0, 0, 1, 2'd3, 32'hFFFFFFFF);
        // R12: read port
        read_chk("R12 sel0", 2'd0, 32'h00005554);
        read_chk("R12 sel1", 2'd1, 32'h13579BDF);
        read_chk("R12 sel2", 2'd2, 32'h8000000B);
        read_chk("R12 sel3", 2'd3, 32'h0);
        // R10: trap beats same-cycle write
        step("R10 collide-epc", 1, 0, 4, 32'h8000, 32'h8004, 32'h0, 32'hE0000001, 1, 2'd0, 32'h11112222);
        step("R10 collide-tval", 1, 1, 3, 32'h8100, 32'h8104, 32'h0, 32'hE0000002, 1, 2'd1, 32'h33334444);
        step("R10 collide-cause", 1, 0, 2, 32'h8200, 32'h8204, 32'hFEEDF00D, 32'h0, 1, 2'd2, 32'h55556666);
        read_chk("R12 after-collide", 2'd1, 32'hFEEDF00D);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", 32'(sbq.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule